// File: doc/BRIEF.md
# Codec Receive Status and Interrupt Flags

This block holds the receive-side status flags of a frame-slotted audio codec serial link. The link receiver sends it one-cycle strobes when a codec status address word or status data word has been captured, and when a new left (slot 3) or right (slot 4) PCM sample is waiting in its data register. The block turns these strobes into sticky ready, request and overrun flags. A CPU reads the flags through one 32-bit register word and clears them by writing zeros.

Each PCM channel has a request flag that says a sample must be read, and an overrun flag that records a lost sample. In DMA mode, a read strobe on a channel's data register clears that channel's request without any CPU write. When an event and a software clear hit the same bit in the same cycle, the event wins, so no event is lost. A single interrupt line combines the request flags and the overrun flags. Each group has its own enable input.

Top module: `rx_flag_reg`

## Requirements
- R1: After reset, or while rst_ni is low, every bit of reg_rdata_o is 0 and irq_o is 0.
- R2: A strobe on sta_addr_evt_i sets bit 22 of reg_rdata_o, and a strobe on sta_data_evt_i sets bit 21, from the cycle after the strobe onward.
- R3: A strobe on left_smp_i sets bit 20 (left request), and a strobe on right_smp_i sets bit 19 (right request), from the next cycle onward.
- R4: With dma_en_i high, a strobe on left_rd_i clears bit 20 and a strobe on right_rd_i clears bit 19 in the next cycle. With dma_en_i low, these read strobes have no effect.
- R5: A new left sample that arrives while bit 20 is set sets bit 13 (left overrun). A new right sample that arrives while bit 19 is set sets bit 12 (right overrun). This does not happen if a DMA-mode read of the same channel occurs in the same cycle. In that case the request stays set and no overrun is recorded.
- R6: A register write with reg_wr_i high clears every flag bit whose position in reg_wdata_i is 0. Flag bits whose position in reg_wdata_i is 1 are left unchanged.
- R7: When a hardware set event and a write-0 clear target the same flag in the same cycle, the flag ends up set.
- R8: Bits 31 to 23, 18 to 14 and 11 to 0 of reg_rdata_o always read 0, whatever is written.
- R9: irq_o is high exactly when req_irq_en_i is high and bit 20 or bit 19 is set, or when ovr_irq_en_i is high and bit 13 or bit 12 is set. The status-ready bits 22 and 21 never drive irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sta_addr_evt_i | input | 1 | Status address word captured (one cycle) |
| sta_data_evt_i | input | 1 | Status data word captured (one cycle) |
| left_smp_i | input | 1 | New slot 3 (left) sample captured |
| right_smp_i | input | 1 | New slot 4 (right) sample captured |
| left_rd_i | input | 1 | Left PCM data register read |
| right_rd_i | input | 1 | Right PCM data register read |
| dma_en_i | input | 1 | DMA mode: data reads clear requests |
| reg_wr_i | input | 1 | Flag register write strobe |
| reg_wdata_i | input | 32 | Write data; a 0 clears the flag at that position |
| reg_rdata_o | output | 32 | Current flag register value |
| req_irq_en_i | input | 1 | Enable of request flags onto irq_o |
| ovr_irq_en_i | input | 1 | Enable of overrun flags onto irq_o |
| irq_o | output | 1 | Interrupt request |

## Verification
Several rules are checked on every cycle:
- Every strobe sets its flag in the next cycle.
- A DMA-mode read with no new sample clears the request.
- A sample that arrives on a pending request records an overrun unless a DMA-mode read happens in the same cycle.
- A set beats a same-cycle write-0.
- The reserved bits stay zero.
- irq_o follows the enabled flag groups.

Other behaviour only shows up in the bench's scenarios:
- Writing ones has no effect on flags that are already set.
- A read without DMA mode leaves the request set.
- Flags hold their value through idle cycles.
- Reset can be asserted in the middle of a run.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned NUM_CH       = 2;   // 0: left (slot 3), 1: right (slot 4)
  localparam int unsigned STA_ADDR_BIT = 22;
  localparam int unsigned STA_DATA_BIT = 21;
  localparam int unsigned REQ_BASE     = 20;  // channel n request at REQ_BASE - n
  localparam int unsigned OVR_BASE     = 13;  // channel n overrun at OVR_BASE - n

  function automatic int unsigned req_bit(input int unsigned ch);
    return REQ_BASE - ch;
  endfunction

  function automatic int unsigned ovr_bit(input int unsigned ch);
    return OVR_BASE - ch;
  endfunction
endpackage

// File: rtl/rx_sticky_flag.sv
module rx_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/rx_pcm_chan.sv
module rx_pcm_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic rd_i,
  input  logic dma_en_i,
  input  logic wclr_req_i,
  input  logic wclr_ovr_i,
  output logic req_o,
  output logic ovr_o
);
  logic dma_rd;
  logic ovr_set;
  logic req_clr;

  assign dma_rd  = dma_en_i & rd_i;
  assign req_clr = wclr_req_i | dma_rd;
  // sample lands on a pending request that is not drained this cycle
  assign ovr_set = smp_i & req_o & ~dma_rd;

  rx_sticky_flag u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (smp_i),
    .clr_i (req_clr),
    .q_o   (req_o)
  );

  rx_sticky_flag u_ovr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ovr_set),
    .clr_i (wclr_ovr_i),
    .q_o   (ovr_o)
  );
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] ovr_i,
  input  logic           req_en_i,
  input  logic           ovr_en_i,
  output logic           irq_o
);
  assign irq_o = (req_en_i & (|req_i)) | (ovr_en_i & (|ovr_i));
endmodule

// File: rtl/rx_flag_reg.sv
module rx_flag_reg
  import rx_flag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sta_addr_evt_i,
  input  logic             sta_data_evt_i,
  input  logic             left_smp_i,
  input  logic             right_smp_i,
  input  logic             left_rd_i,
  input  logic             right_rd_i,
  input  logic             dma_en_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             req_irq_en_i,
  input  logic             ovr_irq_en_i,
  output logic             irq_o
);
  logic [REG_W-1:0]  wclr;
  logic [NUM_CH-1:0] smp, rd, req, ovr;
  logic              sta_addr_q, sta_data_q;
  logic              unused_wdata;

  assign wclr = {REG_W{reg_wr_i}} & ~reg_wdata_i;
  assign smp  = {right_smp_i, left_smp_i};
  assign rd   = {right_rd_i, left_rd_i};
  assign unused_wdata = ^reg_wdata_i;

  rx_sticky_flag u_sta_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sta_addr_evt_i),
    .clr_i (wclr[STA_ADDR_BIT]),
    .q_o   (sta_addr_q)
  );

  rx_sticky_flag u_sta_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sta_data_evt_i),
    .clr_i (wclr[STA_DATA_BIT]),
    .q_o   (sta_data_q)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    rx_pcm_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (smp[ch]),
      .rd_i      (rd[ch]),
      .dma_en_i  (dma_en_i),
      .wclr_req_i(wclr[req_bit(ch)]),
      .wclr_ovr_i(wclr[ovr_bit(ch)]),
      .req_o     (req[ch]),
      .ovr_o     (ovr[ch])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[STA_ADDR_BIT] = sta_addr_q;
    reg_rdata_o[STA_DATA_BIT] = sta_data_q;
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      reg_rdata_o[req_bit(ch)] = req[ch];
      reg_rdata_o[ovr_bit(ch)] = ovr[ch];
    end
  end

  rx_irq_gen #(.NCH(NUM_CH)) u_irq (
    .req_i   (req),
    .ovr_i   (ovr),
    .req_en_i(req_irq_en_i),
    .ovr_en_i(ovr_irq_en_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/rx_flag_reg_chk.sv
module rx_flag_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sta_addr_evt_i,
  input logic        sta_data_evt_i,
  input logic        left_smp_i,
  input logic        right_smp_i,
  input logic        left_rd_i,
  input logic        right_rd_i,
  input logic        dma_en_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        req_irq_en_i,
  input logic        ovr_irq_en_i,
  input logic        irq_o
);
  assert_sta_addr_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta_addr_evt_i |=> reg_rdata_o[22]);
  assert_sta_data_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta_data_evt_i |=> reg_rdata_o[21]);
  assert_left_req_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_smp_i |=> reg_rdata_o[20]);
  assert_right_req_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_smp_i |=> reg_rdata_o[19]);
  assert_left_dma_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && left_rd_i && !left_smp_i) |=> !reg_rdata_o[20]);
  assert_right_dma_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && right_rd_i && !right_smp_i) |=> !reg_rdata_o[19]);
  assert_left_ovr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_smp_i && reg_rdata_o[20] && !(dma_en_i && left_rd_i)) |=> reg_rdata_o[13]);
  assert_right_ovr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (right_smp_i && reg_rdata_o[19] && !(dma_en_i && right_rd_i)) |=> reg_rdata_o[12]);
  assert_no_ovr_on_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_smp_i && dma_en_i && left_rd_i && !reg_rdata_o[13]) |=> !reg_rdata_o[13]);
  assert_set_beats_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sta_data_evt_i && reg_wr_i && !reg_wdata_i[21]) |=> reg_rdata_o[21]);
  assert_rsv_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31:23] == '0) && (reg_rdata_o[18:14] == '0) && (reg_rdata_o[11:0] == '0));
  assert_irq_map_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((req_irq_en_i && (reg_rdata_o[20] || reg_rdata_o[19])) ||
              (ovr_irq_en_i && (reg_rdata_o[13] || reg_rdata_o[12]))));
endmodule

bind rx_flag_reg rx_flag_reg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sta_addr_evt_i(sta_addr_evt_i),
  .sta_data_evt_i(sta_data_evt_i),
  .left_smp_i    (left_smp_i),
  .right_smp_i   (right_smp_i),
  .left_rd_i     (left_rd_i),
  .right_rd_i    (right_rd_i),
  .dma_en_i      (dma_en_i),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .req_irq_en_i  (req_irq_en_i),
  .ovr_irq_en_i  (ovr_irq_en_i),
  .irq_o         (irq_o)
);

// File: tb/rx_flag_reg_tb.sv
`timescale 1ns/1ps
module rx_flag_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sta_addr_evt_i = 0, sta_data_evt_i = 0;
  logic        left_smp_i = 0, right_smp_i = 0;
  logic        left_rd_i = 0, right_rd_i = 0;
  logic        dma_en_i = 0, reg_wr_i = 0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_irq_en_i = 0, ovr_irq_en_i = 0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  rx_flag_reg u_dut (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic        sa, sd, el, er, rl, rr, dma, wr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 0,0,0,0,0,0,0,0, 32'h0,         32'h0000_0000}, // R1 idle after reset
    '{4'd2, 1,0,0,0,0,0,0,0, 32'h0,         32'h0040_0000}, // R2 status address
    '{4'd2, 0,1,0,0,0,0,0,0, 32'h0,         32'h0060_0000}, // R2 status data
    '{4'd3, 0,0,1,0,0,0,0,0, 32'h0,         32'h0070_0000}, // R3 left request
    '{4'd5, 0,0,1,0,0,0,0,0, 32'h0,         32'h0070_2000}, // R5 left overrun
    '{4'd6, 0,0,0,0,0,0,0,1, 32'hFFBF_FFFF, 32'h0030_2000}, // R6 clear bit 22 only
    '{4'd6, 0,0,0,0,0,0,0,1, 32'hFFFF_FFFF, 32'h0030_2000}, // R6 ones change nothing
    '{4'd7, 0,0,0,1,0,0,0,1, 32'h0,         32'h0008_0000}, // R7 set beats clear
    '{4'd4, 0,0,0,0,0,1,0,0, 32'h0,         32'h0008_0000}, // R4 read without DMA ignored
    '{4'd4, 0,0,0,0,0,1,1,0, 32'h0,         32'h0000_0000}, // R4 DMA read clears
    '{4'd3, 0,0,0,1,0,1,1,0, 32'h0,         32'h0008_0000}, // R3 sample with drain, req empty
    '{4'd5, 0,0,0,1,0,1,1,0, 32'h0,         32'h0008_0000}, // R5 drain+sample: no overrun
    '{4'd5, 0,0,0,1,0,0,0,0, 32'h0,         32'h0008_1000}, // R5 right overrun
    '{4'd8, 0,0,0,0,0,0,0,1, 32'h0007_C000, 32'h0000_0000}, // R8 reserved writes ignored
    '{4'd4, 0,0,1,0,1,0,1,0, 32'h0,         32'h0010_0000}  // R4 left sample+DMA read, req was clear
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sta_addr_evt_i = 0; sta_data_evt_i = 0; left_smp_i = 0; right_smp_i = 0;
    left_rd_i = 0; right_rd_i = 0; dma_en_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  // drive on negedge, result is registered at the next posedge, sample 1 ns later
  task automatic step();
    @(posedge clk_i); #1;
    @(negedge clk_i);
    idle_inputs();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset rdata", reg_rdata_o, 32'h0);
    check("R1 reset irq", {31'h0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      sta_addr_evt_i = VEC[i].sa; sta_data_evt_i = VEC[i].sd;
      left_smp_i = VEC[i].el; right_smp_i = VEC[i].er;
      left_rd_i = VEC[i].rl; right_rd_i = VEC[i].rr;
      dma_en_i = VEC[i].dma; reg_wr_i = VEC[i].wr; reg_wdata_i = VEC[i].wdata;
      @(posedge clk_i); #1;
      check($sformatf("R%0d vec %0d", VEC[i].rq, i), reg_rdata_o, VEC[i].exp);
      @(negedge clk_i);
      idle_inputs();
    end

    // R9 irq gating; state is left request only (0x0010_0000)
    check("R9 irq off", {31'h0, irq_o}, 32'h0);
    ovr_irq_en_i = 1; #1;
    check("R9 ovr en, no ovr", {31'h0, irq_o}, 32'h0);
    req_irq_en_i = 1; #1;
    check("R9 req en", {31'h0, irq_o}, 32'h1);
    req_irq_en_i = 0;
    left_smp_i = 1; step();
    check("R5 left overrun again", reg_rdata_o, 32'h0010_2000);
    check("R9 ovr en with ovr", {31'h0, irq_o}, 32'h1);
    reg_wr_i = 1; reg_wdata_i = 32'hFFFF_DFFF; step();
    check("R6 clear left ovr", reg_rdata_o, 32'h0010_0000);
    check("R9 ovr cleared", {31'h0, irq_o}, 32'h0);
    ovr_irq_en_i = 0;
    sta_addr_evt_i = 1; sta_data_evt_i = 1; step();
    req_irq_en_i = 1;
    reg_wr_i = 1; reg_wdata_i = 32'hFFEF_FFFF; step();
    check("R9 status bits no irq", {31'h0, irq_o}, 32'h0);
    check("R2 status hold", reg_rdata_o, 32'h0060_0000);
    step();
    check("R2 flags hold idle", reg_rdata_o, 32'h0060_0000);

    // R1 mid-run reset
    rst_ni = 0; #1;
    check("R1 async reset", reg_rdata_o, 32'h0);
    @(negedge clk_i); rst_ni = 1;
    step();
    check("R1 after reset idle", reg_rdata_o, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule